// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Fast-Line Steering

The block gathers a small set of interrupt request lines and turns them into two processor-facing outputs: an ordinary interrupt line and a fast interrupt line. Each input first passes through a two-flop synchronizer. It is then conditioned, which means optional inversion for the lines that can be active-low, or replacement by a software-written test pattern. The result is gated by an enable mask and steered to one of the two outputs according to a per-line route bit. All requests are levels. A line is pending for exactly as long as its conditioned input is active and its enable bit is set. Nothing is latched.

Software controls the block over a simple word-addressed register bus. The bus has one address, a write strobe with write data, and a read strobe. Read data is registered and appears on the cycle after the read strobe. The enable mask has no plain write port. Bits are turned on through a set register and turned off through a clear register, so one driver can change its own line without reading the mask first. The bus data width equals the number of sources, and bit i always refers to source i.

Top module: `irq_router`

## Requirements
- R1: While reset is high and on the cycle after it, `irq_o`, `fiq_o` and `rd_data` are 0. Reset leaves the mask, route, polarity, source-select and test registers at 0.
- R2: A write to offset 0 sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. A read of offset 0 returns the mask.
- R3: A write to offset 1 clears every mask bit whose write-data bit is 1. Writing all ones clears the whole mask. A read of offset 1 returns 0.
- R4: A read of offset 3 returns the conditioned inputs before masking.
- R5: A read of offset 2 returns the conditioned inputs ANDed with the mask. A masked line never drives either output.
- R6: The route register at offset 4 steers each line. Bit 0 sends the line to `irq_o` and bit 1 sends it to `fiq_o`. Each output is the registered OR of the pending lines steered to it.
- R7: The polarity register at offset 5 inverts a line when its bit is 1, but only for the active-low-capable lines, which by default are sources 2 and 4. Bits for the other lines are not stored: they read back as 0 and have no effect.
- R8: When bit 0 of offset 6 is 1, the test register at offset 7 replaces the synchronized inputs as the conditioned value, and no polarity is applied. When that bit is 0, the real inputs are used. Both registers read back their values.
- R9: A pending line clears as soon as its input goes inactive. No request is held once its source goes away.
- R10: An input change driven before clock edge k reaches `irq_o` or `fiq_o` at edge k+2. A register write at edge k affects the outputs at edge k+1. A read strobe at edge k presents its data after edge k.
- R11: An offset with no register reads as 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word offset for reads and writes |
| wr_data | input | NUM_SRC | Write data, one bit per source |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | NUM_SRC | Registered read data |
| src_in | input | NUM_SRC | Asynchronous interrupt request lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench checks the mask registers with partial writes. A design that overwrote the mask instead of OR-ing into it would lose the first enable after a second set. It drives every polarity bit high and expects only the two capable lines to invert. A design that stored all polarity bits would show a raw status with every line flipped. It also checks that the test source bypasses polarity and ignores the real inputs, that a request drops once its input falls, and that an input change reaches the outputs on the third sampled edge. An extra or missing synchronizer stage would move that edge.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  localparam int OFS_ENA_SET = 0;
  localparam int OFS_ENA_CLR = 1;
  localparam int OFS_PEND    = 2;
  localparam int OFS_RAW     = 3;
  localparam int OFS_ROUTE   = 4;
  localparam int OFS_POL     = 5;
  localparam int OFS_SEL     = 6;
  localparam int OFS_TEST    = 7;

  typedef enum logic [3:0] {
    RID_ENA_SET,
    RID_ENA_CLR,
    RID_PEND,
    RID_RAW,
    RID_ROUTE,
    RID_POL,
    RID_SEL,
    RID_TEST,
    RID_NONE
  } rid_e;

  function automatic rid_e decode_rid(input logic [31:0] a);
    case (a)
      OFS_ENA_SET: return RID_ENA_SET;
      OFS_ENA_CLR: return RID_ENA_CLR;
      OFS_PEND:    return RID_PEND;
      OFS_RAW:     return RID_RAW;
      OFS_ROUTE:   return RID_ROUTE;
      OFS_POL:     return RID_POL;
      OFS_SEL:     return RID_SEL;
      OFS_TEST:    return RID_TEST;
      default:     return RID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/irqr_regs.sv
module irqr_regs
  import irqr_pkg::*;
#(
  parameter int             N      = 10,
  parameter int             ADDR_W = 4,
  parameter logic [N-1:0]   LOWCAP = N'(20)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [N-1:0]      raw_i,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      rd_data,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      route_o,
  output logic [N-1:0]      pol_o,
  output logic              sel_o,
  output logic [N-1:0]      test_o
);

  rid_e         rid;
  logic [N-1:0] rd_next;

  assign rid = decode_rid(32'(addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o  <= '0;
      route_o <= '0;
      pol_o   <= '0;
      sel_o   <= 1'b0;
      test_o  <= '0;
    end else if (wr_en) begin
      case (rid)
        RID_ENA_SET: mask_o  <= mask_o | wr_data;
        RID_ENA_CLR: mask_o  <= mask_o & ~wr_data;
        RID_ROUTE:   route_o <= wr_data;
        RID_POL:     pol_o   <= wr_data & LOWCAP;
        RID_SEL:     sel_o   <= wr_data[0];
        RID_TEST:    test_o  <= wr_data;
        default:     ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (rid)
      RID_ENA_SET: rd_next    = mask_o;
      RID_PEND:    rd_next    = pend_i;
      RID_RAW:     rd_next    = raw_i;
      RID_ROUTE:   rd_next    = route_o;
      RID_POL:     rd_next    = pol_o;
      RID_SEL:     rd_next[0] = sel_o;
      RID_TEST:    rd_next    = test_o;
      default:     rd_next    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/irqr_cond.sv
module irqr_cond #(
  parameter int           N      = 10,
  parameter logic [N-1:0] LOWCAP = N'(20)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] pol_i,
  input  logic         sel_i,
  input  logic [N-1:0] test_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] route_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o,
  output logic         fiq_o
);

  logic [N-1:0] level;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (LOWCAP[i]) begin : g_inv
      assign level[i] = sync_i[i] ^ pol_i[i];
    end else begin : g_pass
      assign level[i] = sync_i[i] | (pol_i[i] & 1'b0);
    end
  end

  assign raw_o  = sel_i ? test_i : level;
  assign pend_o = raw_o & mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |(pend_o & ~route_i);
      fiq_o <= |(pend_o & route_i);
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int                   NUM_SRC     = 10,
  parameter int                   ADDR_W      = 4,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0]   LOWCAP_MASK = NUM_SRC'(20)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [NUM_SRC-1:0] rd_data,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_o,
  output logic               fiq_o
);

  logic [NUM_SRC-1:0] sync_q;
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] route_q;
  logic [NUM_SRC-1:0] pol_q;
  logic [NUM_SRC-1:0] test_q;
  logic               sel_q;

  irqr_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (src_in),
    .q   (sync_q)
  );

  irqr_regs #(.N(NUM_SRC), .ADDR_W(ADDR_W), .LOWCAP(LOWCAP_MASK)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .raw_i   (raw),
    .pend_i  (pend),
    .rd_data (rd_data),
    .mask_o  (mask_q),
    .route_o (route_q),
    .pol_o   (pol_q),
    .sel_o   (sel_q),
    .test_o  (test_q)
  );

  irqr_cond #(.N(NUM_SRC), .LOWCAP(LOWCAP_MASK)) u_cond (
    .clk     (clk),
    .rst     (rst),
    .sync_i  (sync_q),
    .pol_i   (pol_q),
    .sel_i   (sel_q),
    .test_i  (test_q),
    .mask_i  (mask_q),
    .route_i (route_q),
    .raw_o   (raw),
    .pend_o  (pend),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
  parameter int N      = 10,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      wr_data,
  input logic              wr_en,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [N-1:0]      mask,
  input logic [N-1:0]      route,
  input logic [N-1:0]      pend,
  input logic [N-1:0]      raw,
  input logic [N-1:0]      test,
  input logic              sel
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq_o && !fiq_o)); // R1

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(irqr_pkg::OFS_ENA_SET)) |=> ((mask & $past(wr_data)) == $past(wr_data))); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(mask)); // R2

  AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(irqr_pkg::OFS_ENA_CLR) && wr_data == '1) |=> (mask == '0)); // R3

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> (!irq_o && !fiq_o)); // R5

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst) irq_o |-> $past(|(pend & ~route))); // R6

  AST_FIQ_SOURCE: assert property (@(posedge clk) disable iff (rst) fiq_o |-> $past(|(pend & route))); // R6

  AST_TEST_STANDS_IN: assert property (@(posedge clk) disable iff (rst) sel |-> (raw == test)); // R8

endmodule

bind irq_router irqr_chk #(.N(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_data (wr_data),
  .wr_en   (wr_en),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .mask    (mask_q),
  .route   (route_q),
  .pend    (pend),
  .raw     (raw),
  .test    (test_q),
  .sel     (sel_q)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;

  localparam int N  = 10;
  localparam int AW = 4;
  localparam logic [N-1:0] CAP = 10'h014;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wr_data = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [N-1:0]  rd_data;
  logic [N-1:0]  src = '0;
  logic          irq_o, fiq_o;

  int total = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .src_in(src), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // Behavioural reference model
  logic [N-1:0] m_mask, m_route, m_pol, m_test, m_s1, m_s2, m_raw, m_pend, m_rd;
  logic         m_sel, m_irq, m_fiq;

  always @(posedge clk) begin
    if (rst) begin
      m_mask = '0; m_route = '0; m_pol = '0; m_test = '0; m_sel = 1'b0;
      m_s1 = '0; m_s2 = '0; m_rd = '0; m_irq = 1'b0; m_fiq = 1'b0;
    end else begin
      m_raw  = m_sel ? m_test : (m_s2 ^ (m_pol & CAP));
      m_pend = m_raw & m_mask;
      m_irq  = |(m_pend & ~m_route);
      m_fiq  = |(m_pend & m_route);
      if (rd_en) begin
        case (int'(addr))
          0: m_rd = m_mask;
          2: m_rd = m_pend;
          3: m_rd = m_raw;
          4: m_rd = m_route;
          5: m_rd = m_pol;
          6: m_rd = {{(N-1){1'b0}}, m_sel};
          7: m_rd = m_test;
          default: m_rd = '0;
        endcase
      end
      if (wr_en) begin
        case (int'(addr))
          0: m_mask  = m_mask | wr_data;
          1: m_mask  = m_mask & ~wr_data;
          4: m_route = wr_data;
          5: m_pol   = wr_data & CAP;
          6: m_sel   = wr_data[0];
          7: m_test  = wr_data;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = src;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      check("R6 model irq_o", 32'(irq_o), 32'(m_irq));
      check("R6 model fiq_o", 32'(fiq_o), 32'(m_fiq));
      check("R10 model rd_data", 32'(rd_data), 32'(m_rd));
    end
  end

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    addr = AW'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic outs(input logic ei, input logic ef, input string tag);
    check({tag, " irq_o"}, 32'(irq_o), 32'(ei));
    check({tag, " fiq_o"}, 32'(fiq_o), 32'(ef));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(4);
    outs(1'b0, 1'b0, "R1 in reset");
    check("R1 rd_data in reset", 32'(rd_data), 0);
    @(negedge clk); rst = 1'b0; started = 1;
    @(negedge clk);
    outs(1'b0, 1'b0, "R1 after reset");
    rd_chk(0, '0, "R1 mask reset");
    rd_chk(4, '0, "R1 route reset");
    rd_chk(5, '0, "R1 pol reset");
    rd_chk(6, '0, "R1 sel reset");

    src = 10'h021; idle(4);
    rd_chk(3, 10'h021, "R4 raw status");
    rd_chk(2, 10'h000, "R5 pending masked");
    outs(1'b0, 1'b0, "R5 all masked");

    wr(0, 10'h001); idle(2);
    outs(1'b1, 1'b0, "R2 enable line0");
    rd_chk(0, 10'h001, "R2 mask read");
    wr(0, 10'h020);
    rd_chk(0, 10'h021, "R2 zeros keep bits");
    rd_chk(2, 10'h021, "R5 pending read");
    rd_chk(1, 10'h000, "R3 clear reads zero");

    wr(4, 10'h020); idle(2);
    outs(1'b1, 1'b1, "R6 split routing");
    wr(1, 10'h001); idle(2);
    outs(1'b0, 1'b1, "R6 fast only");

    src = 10'h000; idle(4);
    outs(1'b0, 1'b0, "R9 level drop");
    rd_chk(2, 10'h000, "R9 pending cleared");

    wr(5, 10'h3FF);
    rd_chk(5, 10'h014, "R7 pol readback");
    rd_chk(3, 10'h014, "R7 only capable invert");
    wr(0, 10'h3FF); idle(2);
    outs(1'b1, 1'b0, "R7 active-low pending");
    src = 10'h014; idle(4);
    outs(1'b0, 1'b0, "R7 active-low released");

    wr(7, 10'h200);
    wr(6, 10'h001);
    rd_chk(3, 10'h200, "R8 test source raw");
    rd_chk(7, 10'h200, "R8 test readback");
    wr(4, 10'h200); idle(2);
    outs(1'b0, 1'b1, "R8 test to fast");
    src = 10'h000; idle(4);
    rd_chk(3, 10'h200, "R8 real inputs ignored");
    wr(6, 10'h000);
    rd_chk(3, 10'h014, "R8 back to real");

    wr(1, 10'h3FF);
    rd_chk(0, 10'h000, "R3 clear all");
    wr(5, 10'h000);
    wr(4, 10'h000);
    wr(0, 10'h002); idle(4);
    outs(1'b0, 1'b0, "R10 before change");
    src = 10'h002;
    @(negedge clk); outs(1'b0, 1'b0, "R10 edge1");
    @(negedge clk); outs(1'b0, 1'b0, "R10 edge2");
    @(negedge clk); outs(1'b1, 1'b0, "R10 edge3");

    wr(9, 10'h3FF);
    rd_chk(9, 10'h000, "R11 unmapped read");
    rd_chk(0, 10'h002, "R11 mask untouched");
    rd_chk(4, 10'h000, "R11 route untouched");
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule